// File: doc/BRIEF.md
# CAN Message Buffer Formatter

This block moves a CAN frame between a parallel form (identifier, extended flag, remote flag, length code, up to eight data bytes) and the byte-per-word buffer window of a CAN controller. Each buffer slot holds one byte, and consecutive slots are `SLOT_STRIDE` address units apart. Slot 0 carries a frame-info byte. The identifier is left-justified across the next slots. Data bytes follow the identifier: from slot 3 for a standard frame and from slot 5 for an extended frame.

A transmit job is started with `tx_start`. It writes the identifier slots, then the data slots, then the frame-info slot, and then raises `xmit_req` for one cycle. A receive job is started with `rx_start`. It reads the frame-info slot first, then the identifier and data slots in ascending order, and presents the rebuilt frame on the `out_*` ports. Both jobs end with a one-cycle `done` pulse, after which the block returns to idle. The buffer is accessed one slot per cycle. Read data is taken combinationally in the same cycle as `buf_rd`.

Top module: `can_slot_formatter`

## Requirements
- R1: Slot 0 holds the frame-info byte. Bit 7 is the extended flag, bit 6 is the remote flag, bits 3:0 are the length code, and bits 5:4 are written as 0. Slot n sits at address `BASE_ADDR + n*SLOT_STRIDE`.
- R2: For a standard frame, slot 1 holds identifier bits 10:3. Slot 2 bits 7:5 hold identifier bits 2:0, and slot 2 bits 4:0 are written as 0 and ignored on read. A received standard identifier has bits 28:11 equal to 0.
- R3: For an extended frame, slots 1, 2 and 3 hold identifier bits 28:21, 20:13 and 12:5. Slot 4 bits 7:3 hold identifier bits 4:0, and slot 4 bits 2:0 are written as 0 and ignored on read.
- R4: Data byte i (bits 8i+7:8i of the data bus) sits in the slot directly after the identifier slots plus i.
- R5: The number of data bytes is the length code, limited to 8. A length code from 9 to 15 moves exactly 8 bytes and is kept unchanged in the info byte and on `out_len`.
- R6: A transmit writes one slot per cycle in back-to-back cycles, in this order: identifier slots ascending, then data slots ascending (also for a remote frame), then slot 0. `xmit_req` pulses in the cycle after the slot 0 write.
- R7: A receive reads slot 0 first, then the identifier and data slots ascending, one per cycle in back-to-back cycles. It rebuilds the flags, length code, identifier and data. Info bits 5:4 are ignored, and data bytes beyond the count read as 0.
- R8: On receive, a remote frame reads no data slots and returns all-zero data, whatever its length code.
- R9: `done` pulses for one cycle, in the cycle after `xmit_req` (transmit) or after the last read (receive). The block is idle in the next cycle. A start request seen while busy is ignored.
- R10: After reset the block is idle: `busy`, `done`, `xmit_req`, `buf_wr` and `buf_rd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Start a transmit job from the `in_*` frame (has priority) |
| rx_start | input | 1 | Start a receive job |
| in_ext | input | 1 | Frame to send is extended |
| in_rtr | input | 1 | Frame to send is remote |
| in_len | input | 4 | Length code of frame to send |
| in_id | input | 29 | Identifier to send (bits 10:0 used for standard) |
| in_data | input | 64 | Data to send, byte i at bits 8i+7:8i |
| buf_wr | output | 1 | Buffer slot write strobe |
| buf_rd | output | 1 | Buffer slot read strobe |
| buf_addr | output | ADDR_W | Slot address |
| buf_wdata | output | 8 | Slot write byte |
| buf_rdata | input | 8 | Slot read byte, valid with `buf_rd` |
| xmit_req | output | 1 | One-cycle transmit request after the frame-info write |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle job completion pulse |
| out_ext | output | 1 | Extended flag of frame held |
| out_rtr | output | 1 | Remote flag of frame held |
| out_len | output | 4 | Length code of frame held |
| out_id | output | 29 | Identifier of frame held |
| out_data | output | 64 | Data of frame held |

## Verification
The bench targets the length codes 0, 8 and 9 to 15. A design that does not limit the length would run past slot 12 or read garbage into the data. It also sends all-ones extended identifiers, where a shift mistake in the slot 4 packing would corrupt bits 4:0. It sends remote frames with non-zero length: on receive a wrong design would fetch data slots, and on transmit it would drop them. Receive buffers are filled with junk in the unused low bits, in info bits 5:4 and in slots past the count, to catch decoding that does not mask these bits. A start request raised in the middle of a job, and the exact cycles of `xmit_req` and `done`, expose wrong ordering, where the info byte is not written last, and extra or missing pulses.

// File: rtl/can_fmt_pkg.sv
package can_fmt_pkg;

    typedef struct packed {
        logic        ext;
        logic        rtr;
        logic [3:0]  len;
        logic [28:0] id;
        logic [63:0] data;
    } can_frame_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TX_SLOT,
        S_TX_INFO,
        S_TX_REQ,
        S_RX_INFO,
        S_RX_SLOT,
        S_DONE
    } fmt_state_e;

    // number of data bytes moved for a length code
    function automatic logic [3:0] byte_count(input logic [3:0] len);
        return (len > 4'd8) ? 4'd8 : len;
    endfunction

    // first data slot
    function automatic logic [3:0] data_base(input logic ext);
        return ext ? 4'd5 : 4'd3;
    endfunction

    // last slot of a job given the number of data bytes
    function automatic logic [3:0] last_slot(input logic ext, input logic [3:0] nbytes);
        return (ext ? 4'd4 : 4'd2) + nbytes;
    endfunction

endpackage

// File: rtl/can_slot_encode.sv
module can_slot_encode
    import can_fmt_pkg::*;
(
    input  can_frame_t frm,
    input  logic [3:0] slot,
    output logic [7:0] byte_o
);
    logic [2:0] didx;
    logic [7:0] dbyte;

    always_comb begin
        didx  = 3'(slot - data_base(frm.ext));
        dbyte = frm.data[8*didx +: 8];
        if (slot == 4'd0) begin
            byte_o = {frm.ext, frm.rtr, 2'b00, frm.len};
        end else if (frm.ext) begin
            case (slot)
                4'd1:    byte_o = frm.id[28:21];
                4'd2:    byte_o = frm.id[20:13];
                4'd3:    byte_o = frm.id[12:5];
                4'd4:    byte_o = {frm.id[4:0], 3'b000};
                default: byte_o = dbyte;
            endcase
        end else begin
            case (slot)
                4'd1:    byte_o = frm.id[10:3];
                4'd2:    byte_o = {frm.id[2:0], 5'b00000};
                default: byte_o = dbyte;
            endcase
        end
    end
endmodule

// File: rtl/can_slot_decode.sv
module can_slot_decode
    import can_fmt_pkg::*;
(
    input  can_frame_t frm_i,
    input  logic [3:0] slot,
    input  logic [7:0] byte_i,
    output can_frame_t frm_o
);
    logic [2:0] didx;

    always_comb begin
        didx  = 3'(slot - data_base(frm_i.ext));
        frm_o = frm_i;
        if (slot == 4'd0) begin
            frm_o     = '0;
            frm_o.ext = byte_i[7];
            frm_o.rtr = byte_i[6];
            frm_o.len = byte_i[3:0];
        end else if (frm_i.ext) begin
            case (slot)
                4'd1:    frm_o.id[28:21] = byte_i;
                4'd2:    frm_o.id[20:13] = byte_i;
                4'd3:    frm_o.id[12:5]  = byte_i;
                4'd4:    frm_o.id[4:0]   = byte_i[7:3];
                default: frm_o.data[8*didx +: 8] = byte_i;
            endcase
        end else begin
            case (slot)
                4'd1:    frm_o.id[10:3] = byte_i;
                4'd2:    frm_o.id[2:0]  = byte_i[7:5];
                default: frm_o.data[8*didx +: 8] = byte_i;
            endcase
        end
    end
endmodule

// File: rtl/can_slot_formatter.sv
module can_slot_formatter
    import can_fmt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SLOT_STRIDE = 4,
    parameter int BASE_ADDR   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic              rx_start,
    input  logic              in_ext,
    input  logic              in_rtr,
    input  logic [3:0]        in_len,
    input  logic [28:0]       in_id,
    input  logic [63:0]       in_data,
    output logic              buf_wr,
    output logic              buf_rd,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata,
    output logic              xmit_req,
    output logic              busy,
    output logic              done,
    output logic              out_ext,
    output logic              out_rtr,
    output logic [3:0]        out_len,
    output logic [28:0]       out_id,
    output logic [63:0]       out_data
);
    localparam logic [ADDR_W-1:0] INFO_ADDR = ADDR_W'(BASE_ADDR);

    typedef struct packed {
        fmt_state_e st;
        logic [3:0] slot;
        can_frame_t frm;
    } regs_t;

    regs_t      r_d, r_q;
    can_frame_t dec_frm;
    logic [7:0] enc_byte;
    logic [3:0] tx_last, rx_last;

    can_slot_encode u_enc (
        .frm    (r_q.frm),
        .slot   (r_q.slot),
        .byte_o (enc_byte)
    );

    can_slot_decode u_dec (
        .frm_i  (r_q.frm),
        .slot   (r_q.slot),
        .byte_i (buf_rdata),
        .frm_o  (dec_frm)
    );

    always_comb begin
        r_d     = r_q;
        tx_last = last_slot(r_q.frm.ext, byte_count(r_q.frm.len));
        rx_last = last_slot(r_q.frm.ext, r_q.frm.rtr ? 4'd0 : byte_count(r_q.frm.len));
        case (r_q.st)
            S_IDLE: begin
                if (tx_start) begin
                    r_d.frm  = '{ext: in_ext, rtr: in_rtr, len: in_len, id: in_id, data: in_data};
                    r_d.st   = S_TX_SLOT;
                    r_d.slot = 4'd1;
                end else if (rx_start) begin
                    r_d.frm  = '0;
                    r_d.st   = S_RX_INFO;
                    r_d.slot = 4'd0;
                end
            end
            S_TX_SLOT: begin
                if (r_q.slot == tx_last) begin
                    r_d.st   = S_TX_INFO;
                    r_d.slot = 4'd0;
                end else begin
                    r_d.slot = r_q.slot + 4'd1;
                end
            end
            S_TX_INFO: r_d.st = S_TX_REQ;
            S_TX_REQ:  r_d.st = S_DONE;
            S_RX_INFO: begin
                r_d.frm  = dec_frm;
                r_d.st   = S_RX_SLOT;
                r_d.slot = 4'd1;
            end
            S_RX_SLOT: begin
                r_d.frm = dec_frm;
                if (r_q.slot == rx_last) begin
                    r_d.st = S_DONE;
                end else begin
                    r_d.slot = r_q.slot + 4'd1;
                end
            end
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign buf_wr    = (r_q.st == S_TX_SLOT) || (r_q.st == S_TX_INFO);
    assign buf_rd    = (r_q.st == S_RX_INFO) || (r_q.st == S_RX_SLOT);
    assign buf_addr  = ADDR_W'(BASE_ADDR + int'(r_q.slot) * SLOT_STRIDE);
    assign buf_wdata = enc_byte;
    assign xmit_req  = (r_q.st == S_TX_REQ);
    assign done      = (r_q.st == S_DONE);
    assign busy      = (r_q.st != S_IDLE);
    assign out_ext   = r_q.frm.ext;
    assign out_rtr   = r_q.frm.rtr;
    assign out_len   = r_q.frm.len;
    assign out_id    = r_q.frm.id;
    assign out_data  = r_q.frm.data;

    // R6: the request follows the frame-info write
    a_r6_req_after_info: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_req |-> $past(buf_wr && buf_addr == INFO_ADDR));

    // R6: the frame-info write is the last write of a job
    a_r6_info_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && buf_addr == INFO_ADDR) |=> !buf_wr);

    // R7: a receive starts with the frame-info slot
    a_r7_info_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_rd) |-> buf_addr == INFO_ADDR);

    // R9: completion is a single-cycle pulse followed by idle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10: never read and write in one cycle
    a_r10_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_wr && buf_rd));

endmodule

// File: tb/can_slot_formatter_tb.sv
module can_slot_formatter_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, tx_start, rx_start, in_ext, in_rtr;
    logic [3:0]  in_len;
    logic [28:0] in_id;
    logic [63:0] in_data;
    logic        buf_wr, buf_rd, xmit_req, busy, done;
    logic [7:0]  buf_addr, buf_wdata, buf_rdata;
    logic        out_ext, out_rtr;
    logic [3:0]  out_len;
    logic [28:0] out_id;
    logic [63:0] out_data;

    can_slot_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .rx_start(rx_start),
        .in_ext(in_ext), .in_rtr(in_rtr), .in_len(in_len), .in_id(in_id), .in_data(in_data),
        .buf_wr(buf_wr), .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .xmit_req(xmit_req), .busy(busy), .done(done),
        .out_ext(out_ext), .out_rtr(out_rtr), .out_len(out_len), .out_id(out_id), .out_data(out_data)
    );

    logic [7:0] mem [0:15];
    always_comb buf_rdata = mem[4'(buf_addr >> 2)];
    always @(posedge clk) if (buf_wr) mem[4'(buf_addr >> 2)] <= buf_wdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int nb(input logic [3:0] len);
        return (len > 4'd8) ? 8 : int'(len);
    endfunction

    // expected byte in a slot per R1..R4
    function automatic logic [7:0] exp_byte(input logic ext, input logic rtr, input logic [3:0] len,
                                            input logic [28:0] id, input logic [63:0] data, input int s);
        int db;
        db = ext ? 5 : 3;
        if (s == 0) return {ext, rtr, 2'b00, len};
        if (ext) begin
            if (s == 1) return id[28:21];
            if (s == 2) return id[20:13];
            if (s == 3) return id[12:5];
            if (s == 4) return {id[4:0], 3'b000};
        end else begin
            if (s == 1) return id[10:3];
            if (s == 2) return {id[2:0], 5'b00000};
        end
        return data[8*(s-db) +: 8];
    endfunction

    task automatic run_tx(input logic ext, input logic rtr, input logic [3:0] len,
                          input logic [28:0] id, input logic [63:0] data, input bit poke);
        int wslot [0:31];
        int wcyc  [0:31];
        logic [7:0] wbyte [0:31];
        int nw, req_cyc, done_cyc, nexp, dbase;
        int eslot [0:31];
        bit ok;
        nw = 0; req_cyc = -1; done_cyc = -1;
        in_ext = ext; in_rtr = rtr; in_len = len; in_id = id; in_data = data;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            if (poke && cyc == 1) rx_start = 1'b1;
            if (poke && cyc == 2) rx_start = 1'b0;
            if (buf_rd) chk(1'b0, "R9 read during transmit", 64'(buf_addr), 64'hff);
            if (buf_wr && nw < 32) begin
                wslot[nw] = int'(buf_addr) / 4; wbyte[nw] = buf_wdata; wcyc[nw] = cyc; nw++;
            end
            if (xmit_req) req_cyc = cyc;
            if (done) begin done_cyc = cyc; break; end
            @(negedge clk);
        end
        rx_start = 1'b0;
        // expected order per R6
        dbase = ext ? 5 : 3;
        nexp = 0;
        for (int s = 1; s < dbase + nb(len); s++) begin eslot[nexp] = s; nexp++; end
        eslot[nexp] = 0; nexp++;
        chk(nw == nexp, "R5 R6 write count", 64'(nw), 64'(nexp));
        ok = (nw == nexp);
        for (int k = 0; k < nexp && k < nw; k++) begin
            if (wslot[k] != eslot[k] || wcyc[k] != k) ok = 1'b0;
            chk(wbyte[k] == exp_byte(ext, rtr, len, id, data, eslot[k]),
                ext ? "R1 R3 R4 slot byte" : "R1 R2 R4 slot byte",
                64'(wbyte[k]), 64'(exp_byte(ext, rtr, len, id, data, eslot[k])));
        end
        chk(ok, "R6 write order", 64'(nw), 64'(nexp));
        chk(req_cyc == nexp, "R6 request cycle", 64'(req_cyc), 64'(nexp));
        chk(done_cyc == nexp + 1, "R9 done cycle", 64'(done_cyc), 64'(nexp + 1));
        @(negedge clk);
        chk(!busy && !done && !buf_rd, "R9 idle after done", {61'b0, busy, done, buf_rd}, 64'h0);
    endtask

    task automatic run_rx(input logic ext, input logic rtr, input logic [3:0] len,
                          input logic [28:0] id, input logic [63:0] data, input logic [1:0] junk_info);
        int rslot [0:31];
        int rcyc  [0:31];
        int nr, done_cyc, nexp, dbase, n;
        bit ok;
        logic [28:0] eid;
        logic [63:0] edata;
        for (int k = 0; k < 16; k++) mem[k] = 8'($urandom);
        mem[0] = {ext, rtr, junk_info, len};
        if (ext) begin
            mem[1] = id[28:21]; mem[2] = id[20:13]; mem[3] = id[12:5];
            mem[4] = {id[4:0], 3'($urandom)};
        end else begin
            mem[1] = id[10:3]; mem[2] = {id[2:0], 5'($urandom)};
        end
        dbase = ext ? 5 : 3;
        for (int i = 0; i < 8; i++) mem[dbase + i] = data[8*i +: 8];
        n = rtr ? 0 : nb(len);
        eid = ext ? id : {18'b0, id[10:0]};
        edata = '0;
        for (int i = 0; i < n; i++) edata[8*i +: 8] = data[8*i +: 8];
        nr = 0; done_cyc = -1;
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            if (buf_wr) chk(1'b0, "R7 write during receive", 64'(buf_addr), 64'hff);
            if (buf_rd && nr < 32) begin rslot[nr] = int'(buf_addr) / 4; rcyc[nr] = cyc; nr++; end
            if (done) begin done_cyc = cyc; break; end
            @(negedge clk);
        end
        nexp = dbase + n;
        ok = (nr == nexp);
        for (int k = 0; k < nr && k < nexp; k++) if (rslot[k] != k || rcyc[k] != k) ok = 1'b0;
        chk(ok, rtr ? "R8 remote read order" : "R7 read order", 64'(nr), 64'(nexp));
        chk(done_cyc == nexp, "R9 rx done cycle", 64'(done_cyc), 64'(nexp));
        chk({out_ext, out_rtr, out_len} == {ext, rtr, len}, "R1 R7 info fields",
            64'({out_ext, out_rtr, out_len}), 64'({ext, rtr, len}));
        chk(out_id == eid, ext ? "R3 rx identifier" : "R2 rx identifier", 64'(out_id), 64'(eid));
        chk(out_data == edata, rtr ? "R8 remote data zero" : "R4 R5 rx data", out_data, edata);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; tx_start = 1'b0; rx_start = 1'b0;
        in_ext = 1'b0; in_rtr = 1'b0; in_len = '0; in_id = '0; in_data = '0;
        for (int k = 0; k < 16; k++) mem[k] = 8'h00;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !xmit_req && !buf_wr && !buf_rd, "R10 reset state",
            {59'b0, busy, done, xmit_req, buf_wr, buf_rd}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !buf_wr && !buf_rd, "R10 idle after reset", {61'b0, busy, buf_wr, buf_rd}, 64'h0);

        // directed corners
        run_tx(1'b0, 1'b0, 4'd0, 29'h7ff, 64'h0, 1'b0);
        run_tx(1'b0, 1'b0, 4'd8, 29'h1555_5123, 64'h8877_6655_4433_2211, 1'b0);
        run_tx(1'b1, 1'b0, 4'd8, 29'h1fff_ffff, 64'hffee_ddcc_bbaa_9988, 1'b0);
        run_tx(1'b1, 1'b0, 4'd15, 29'h0abc_def1, 64'h0102_0304_0506_0708, 1'b0); // R5 clamp
        run_tx(1'b0, 1'b1, 4'd3, 29'h123, 64'h0000_0000_00c3_b2a1, 1'b1);      // R9 poke
        run_rx(1'b0, 1'b1, 4'd5, 29'h2aa, 64'h1122_3344_5566_7788, 2'b11);     // R8
        run_rx(1'b1, 1'b1, 4'd8, 29'h1fff_ffff, 64'hffff_ffff_ffff_ffff, 2'b10);
        run_rx(1'b0, 1'b0, 4'd12, 29'h7ff, 64'hdead_beef_cafe_f00d, 2'b01);   // R5 clamp
        run_rx(1'b1, 1'b0, 4'd0, 29'h1234_5678, 64'h55, 2'b11);

        // constrained random
        for (int t = 0; t < 40; t++) begin
            run_tx(1'($urandom), 1'($urandom), 4'($urandom), 29'($urandom),
                   {$urandom, $urandom}, (t % 7) == 3);
            run_rx(1'($urandom), 1'($urandom), 4'($urandom), 29'($urandom),
                   {$urandom, $urandom}, 2'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule